// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block is the select stage of an out-of-order instruction window. Each slot of the window holds one entry. An entry carries a valid bit, an operand-ready bit, a class tag, a sequence number and a hold flag for non-speculative work. Every cycle the block picks eligible entries oldest first. Each pick must fit both a cap for the entry's class and a cap on the total for the cycle. The picks go out on a packed issue port, and their slots are released at the next clock edge.

New entries arrive on several insertion lanes. Each lane takes a free slot, and a lane is refused when no free slot is left for it. A non-speculative entry waits until the commit side names its sequence number on a release input, which the block registers for one cycle before using it. A squash input carries a sequence number and removes every entry that is younger than it. Sequence numbers wrap, so age is decided by the sign bit of their modular difference.

Top module: `iss_select`

## Requirements
- R1: Entry a is older than entry b when the top bit of (a - b) mod 2^SEQ_W is set. Issue slot 0 carries the oldest grant, and each following valid slot is strictly younger than the slot before it. A grant may go to an eligible entry only if every older eligible entry, whose class cap is not yet used up, has also been granted.
- R2: Class codes are 0 integer, 1 floating point, 2 branch, 3 memory and 4 misc. An entry inserted with code 5, 6 or 7 is stored, capped and reported as misc (4).
- R3: At most 2 integer grants and at most 1 grant of each other class may be made per cycle, with at most 4 grants in total. A class with nothing eligible leaves its share unused, so the other classes stay under their own caps.
- R4: The issue port is packed from slot 0 upward. Each slot shows a valid bit, the sequence number and the class. Slots without a grant drive zero on their sequence and class.
- R5: A ready, speculative entry inserted in cycle t can be granted in cycle t+1. A granted entry is removed at the end of its grant cycle. An entry inserted with ready low is never granted.
- R6: A non-speculative entry is not granted while held. A release naming its sequence number in cycle t makes it eligible from cycle t+2.
- R7: While squash is asserted, entries whose sequence number is younger than the squash number are not granted, and they are removed at the end of that cycle. Entries that are the same age or older are kept. If a squash and the registered release reach the same entry in one cycle, the entry is removed.
- R8: The free count equals the number of empty slots. The full flag is set exactly when the free count is zero. An insertion lane k is accepted only if it is valid and the free count at the start of the cycle is larger than the number of valid lanes below k. Refused lanes leave no trace. A slot freed by a grant can be filled in the next cycle.
- R9: After reset the window is empty: free count 16, full low and no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | N_LANE | Insertion request per lane |
| ins_ready_i | input | N_LANE | Operands ready for the inserted entry |
| ins_nonspec_i | input | N_LANE | Inserted entry must wait for a release |
| ins_cls_i | input | N_LANE x 3 | Class code per lane |
| ins_seq_i | input | N_LANE x SEQ_W | Sequence number per lane |
| rel_valid_i | input | 1 | Commit-side release strobe |
| rel_seq_i | input | SEQ_W | Sequence number to release |
| sq_valid_i | input | 1 | Squash strobe |
| sq_seq_i | input | SEQ_W | Entries younger than this are flushed |
| iss_valid_o | output | TOT_CAP | Grant valid per issue slot |
| iss_seq_o | output | TOT_CAP x SEQ_W | Sequence number per issue slot |
| iss_cls_o | output | TOT_CAP x 3 | Class per issue slot |
| free_cnt_o | output | clog2(N_ENT+1) | Number of empty window slots |
| full_o | output | 1 | No empty slot left |

## Verification
The bench uses the default build: 16 slots, 8-bit sequence numbers, four insertion lanes, and caps of 2/1/1/1/1 under a total of 4. Four lanes are enough to fill the window in four cycles. They also let a single insertion saturate the integer cap and, together with leftover entries, the total cap. Eight-bit numbers make the wrap at 255 to 0 easy to reach. Release timing, the race between squash and release, and partial acceptance on a nearly full window each take only a few cycles at these sizes.

// File: rtl/iss_pkg.sv
package iss_pkg;
  localparam int unsigned NUM_CLS = 5;

  typedef enum logic [2:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_BR   = 3'd2,
    CLS_MEM  = 3'd3,
    CLS_MISC = 3'd4
  } iss_cls_e;

  // undefined codes fold onto misc
  function automatic logic [2:0] norm_cls(input logic [2:0] c);
    return (c > 3'(CLS_MISC)) ? 3'(CLS_MISC) : c;
  endfunction
endpackage

// File: rtl/iss_slot_alloc.sv
module iss_slot_alloc #(
  parameter int unsigned N_ENT  = 16,
  parameter int unsigned N_LANE = 4,
  parameter int unsigned IDX_W  = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0]             free_i,
  input  logic [N_LANE-1:0]            req_i,
  output logic [N_LANE-1:0]            acc_o,
  output logic [N_LANE-1:0][IDX_W-1:0] slot_o
);
  always_comb begin
    logic [N_ENT-1:0] avail;
    avail  = free_i;
    acc_o  = '0;
    slot_o = '0;
    for (int k = 0; k < N_LANE; k++) begin
      if (req_i[k] && (|avail)) begin
        for (int i = N_ENT - 1; i >= 0; i--) begin
          if (avail[i]) slot_o[k] = IDX_W'(i);
        end
        acc_o[k]            = 1'b1;
        avail[slot_o[k]]    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/iss_pick_round.sv
module iss_pick_round
  import iss_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned CAP_W = 3,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0]              elig_i,
  input  logic [N_ENT-1:0]              taken_i,
  input  logic [N_ENT-1:0][2:0]         cls_i,
  input  logic [N_ENT-1:0][SEQ_W-1:0]   seq_i,
  input  logic [NUM_CLS-1:0][CAP_W-1:0] used_i,
  input  logic [NUM_CLS-1:0][CAP_W-1:0] caps_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [N_ENT-1:0]              taken_o,
  output logic [NUM_CLS-1:0][CAP_W-1:0] used_o
);
  logic [N_ENT-1:0] ok;

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      ok[i] = elig_i[i] & ~taken_i[i] & (used_i[cls_i[i]] < caps_i[cls_i[i]]);
    end
  end

  // linear oldest search, wrap-aware by sign of the difference
  always_comb begin
    logic [SEQ_W-1:0] d;
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      d = seq_i[i] - seq_i[idx_o];
      if (ok[i] && (!hit_o || d[SEQ_W-1])) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    taken_o = taken_i;
    used_o  = used_i;
    if (hit_o) begin
      taken_o[idx_o]        = 1'b1;
      used_o[cls_i[idx_o]]  = used_i[cls_i[idx_o]] + CAP_W'(1);
    end
  end
endmodule

// File: rtl/iss_select.sv
module iss_select
  import iss_pkg::*;
#(
  parameter int unsigned N_ENT    = 16,
  parameter int unsigned SEQ_W    = 8,
  parameter int unsigned N_LANE   = 4,
  parameter int unsigned TOT_CAP  = 4,
  parameter int unsigned CAP_INT  = 2,
  parameter int unsigned CAP_FP   = 1,
  parameter int unsigned CAP_BR   = 1,
  parameter int unsigned CAP_MEM  = 1,
  parameter int unsigned CAP_MISC = 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_LANE-1:0]                ins_valid_i,
  input  logic [N_LANE-1:0]                ins_ready_i,
  input  logic [N_LANE-1:0]                ins_nonspec_i,
  input  logic [N_LANE-1:0][2:0]           ins_cls_i,
  input  logic [N_LANE-1:0][SEQ_W-1:0]     ins_seq_i,
  input  logic                             rel_valid_i,
  input  logic [SEQ_W-1:0]                 rel_seq_i,
  input  logic                             sq_valid_i,
  input  logic [SEQ_W-1:0]                 sq_seq_i,
  output logic [TOT_CAP-1:0]               iss_valid_o,
  output logic [TOT_CAP-1:0][SEQ_W-1:0]    iss_seq_o,
  output logic [TOT_CAP-1:0][2:0]          iss_cls_o,
  output logic [$clog2(N_ENT+1)-1:0]       free_cnt_o,
  output logic                             full_o
);
  localparam int unsigned IDX_W = $clog2(N_ENT);
  localparam int unsigned CNT_W = $clog2(N_ENT + 1);
  localparam int unsigned CAP_W = $clog2(TOT_CAP + 1);
  localparam logic [NUM_CLS-1:0][CAP_W-1:0] CAPS = {
    CAP_W'(CAP_MISC), CAP_W'(CAP_MEM), CAP_W'(CAP_BR), CAP_W'(CAP_FP), CAP_W'(CAP_INT)
  };

  logic [N_ENT-1:0]            vld_q, rdy_q, hold_q;
  logic [N_ENT-1:0][2:0]       cls_q;
  logic [N_ENT-1:0][SEQ_W-1:0] seq_q;
  logic                        rel_vld_q;
  logic [SEQ_W-1:0]            rel_seq_q;

  logic [N_ENT-1:0][SEQ_W-1:0] sq_diff;
  logic [N_ENT-1:0]            sq_kill, elig, grant;
  logic [N_LANE-1:0]           ins_acc;
  logic [N_LANE-1:0][IDX_W-1:0] ins_slot;

  for (genvar i = 0; i < N_ENT; i++) begin : g_kill
    assign sq_diff[i] = seq_q[i] - sq_seq_i;
    assign sq_kill[i] = sq_valid_i & vld_q[i] & (sq_diff[i] != '0) & ~sq_diff[i][SEQ_W-1];
  end

  assign elig = vld_q & rdy_q & ~hold_q & ~sq_kill;

  // one pick per round; rounds chain taken mask and class usage
  for (genvar r = 0; r < TOT_CAP; r++) begin : g_rnd
    logic [N_ENT-1:0]              tk_in, tk_out;
    logic [NUM_CLS-1:0][CAP_W-1:0] us_in, us_out;
    logic                          hit;
    logic [IDX_W-1:0]              idx;

    if (r == 0) begin : g_first
      assign tk_in = '0;
      assign us_in = '0;
    end else begin : g_next
      assign tk_in = g_rnd[r-1].tk_out;
      assign us_in = g_rnd[r-1].us_out;
    end

    iss_pick_round #(
      .N_ENT(N_ENT), .SEQ_W(SEQ_W), .CAP_W(CAP_W), .IDX_W(IDX_W)
    ) u_pick (
      .elig_i (elig),
      .taken_i(tk_in),
      .cls_i  (cls_q),
      .seq_i  (seq_q),
      .used_i (us_in),
      .caps_i (CAPS),
      .hit_o  (hit),
      .idx_o  (idx),
      .taken_o(tk_out),
      .used_o (us_out)
    );

    assign iss_valid_o[r] = hit;
    assign iss_seq_o[r]   = hit ? seq_q[idx] : '0;
    assign iss_cls_o[r]   = hit ? cls_q[idx] : '0;
  end

  assign grant = g_rnd[TOT_CAP-1].tk_out;

  iss_slot_alloc #(
    .N_ENT(N_ENT), .N_LANE(N_LANE), .IDX_W(IDX_W)
  ) u_alloc (
    .free_i(~vld_q),
    .req_i (ins_valid_i),
    .acc_o (ins_acc),
    .slot_o(ins_slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= '0;
      rdy_q     <= '0;
      hold_q    <= '0;
      cls_q     <= '0;
      seq_q     <= '0;
      rel_vld_q <= 1'b0;
      rel_seq_q <= '0;
    end else begin
      rel_vld_q <= rel_valid_i;
      rel_seq_q <= rel_seq_i;
      for (int i = 0; i < N_ENT; i++) begin
        if (grant[i] || sq_kill[i]) begin
          vld_q[i] <= 1'b0;
        end else if (rel_vld_q && vld_q[i] && (seq_q[i] == rel_seq_q)) begin
          hold_q[i] <= 1'b0;
        end
      end
      // allocation only uses slots empty at cycle start
      for (int k = 0; k < N_LANE; k++) begin
        if (ins_acc[k]) begin
          vld_q[ins_slot[k]]  <= 1'b1;
          rdy_q[ins_slot[k]]  <= ins_ready_i[k];
          hold_q[ins_slot[k]] <= ins_nonspec_i[k];
          cls_q[ins_slot[k]]  <= norm_cls(ins_cls_i[k]);
          seq_q[ins_slot[k]]  <= ins_seq_i[k];
        end
      end
    end
  end

  assign free_cnt_o = CNT_W'(N_ENT) - CNT_W'($countones(vld_q));
  assign full_o     = &vld_q;
endmodule

// File: rtl/iss_select_chk.sv
module iss_select_chk
  import iss_pkg::*;
#(
  parameter int unsigned N_ENT    = 16,
  parameter int unsigned SEQ_W    = 8,
  parameter int unsigned N_LANE   = 4,
  parameter int unsigned TOT_CAP  = 4,
  parameter int unsigned CAP_INT  = 2,
  parameter int unsigned CAP_FP   = 1,
  parameter int unsigned CAP_BR   = 1,
  parameter int unsigned CAP_MEM  = 1,
  parameter int unsigned CAP_MISC = 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_LANE-1:0]             ins_valid_i,
  input logic                          sq_valid_i,
  input logic [SEQ_W-1:0]              sq_seq_i,
  input logic [TOT_CAP-1:0]            iss_valid_o,
  input logic [TOT_CAP-1:0][SEQ_W-1:0] iss_seq_o,
  input logic [TOT_CAP-1:0][2:0]       iss_cls_o,
  input logic [$clog2(N_ENT+1)-1:0]    free_cnt_o,
  input logic                          full_o
);
  int cls_cnt [NUM_CLS];
  int cap_of  [NUM_CLS];
  int iss_n, acc_n;

  assign cap_of[0] = int'(CAP_INT);
  assign cap_of[1] = int'(CAP_FP);
  assign cap_of[2] = int'(CAP_BR);
  assign cap_of[3] = int'(CAP_MEM);
  assign cap_of[4] = int'(CAP_MISC);

  always_comb begin
    for (int c = 0; c < NUM_CLS; c++) begin
      cls_cnt[c] = 0;
      for (int r = 0; r < TOT_CAP; r++) begin
        if (iss_valid_o[r] && (int'(iss_cls_o[r]) == c)) cls_cnt[c]++;
      end
    end
    iss_n = $countones(iss_valid_o);
    acc_n = ($countones(ins_valid_i) < int'(free_cnt_o)) ? $countones(ins_valid_i)
                                                         : int'(free_cnt_o);
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    AST_CLASS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cls_cnt[c] <= cap_of[c]); // R3
  end

  for (genvar r = 1; r < TOT_CAP; r++) begin : g_slot
    logic [SEQ_W-1:0] age_d;
    assign age_d = iss_seq_o[r-1] - iss_seq_o[r];
    AST_SLOT_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[r] |-> iss_valid_o[r-1]); // R4
    AST_SLOT_AGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[r] |-> age_d[SEQ_W-1]); // R1
  end

  for (genvar r = 0; r < TOT_CAP; r++) begin : g_sq
    logic [SEQ_W-1:0] sq_d;
    assign sq_d = iss_seq_o[r] - sq_seq_i;
    AST_SQUASH_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sq_valid_i && iss_valid_o[r]) |-> ((sq_d == '0) || sq_d[SEQ_W-1])); // R7
  end

  AST_FREE_ACCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sq_valid_i |=> int'(free_cnt_o) == int'($past(free_cnt_o)) + $past(iss_n) - $past(acc_n)); // R8

  AST_FULL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (free_cnt_o == '0)); // R8

  AST_FULL_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && (iss_valid_o == '0) && !sq_valid_i) |=> full_o); // R8
endmodule

bind iss_select iss_select_chk #(
  .N_ENT(N_ENT), .SEQ_W(SEQ_W), .N_LANE(N_LANE), .TOT_CAP(TOT_CAP),
  .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR), .CAP_MEM(CAP_MEM), .CAP_MISC(CAP_MISC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ins_valid_i(ins_valid_i),
  .sq_valid_i (sq_valid_i),
  .sq_seq_i   (sq_seq_i),
  .iss_valid_o(iss_valid_o),
  .iss_seq_o  (iss_seq_o),
  .iss_cls_o  (iss_cls_o),
  .free_cnt_o (free_cnt_o),
  .full_o     (full_o)
);

// File: tb/iss_select_tb_top.sv
module iss_select_tb_top;
  localparam int N = 16;
  localparam int L = 4;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [L-1:0]       ins_v, ins_r, ins_ns;
  logic [L-1:0][2:0]  ins_c;
  logic [L-1:0][7:0]  ins_s;
  logic               rel_v, sq_v;
  logic [7:0]         rel_s, sq_s;
  logic [T-1:0]       iss_v;
  logic [T-1:0][7:0]  iss_s;
  logic [T-1:0][2:0]  iss_c;
  logic [4:0]         free_cnt;
  logic               full;

  iss_select dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_v), .ins_ready_i(ins_r), .ins_nonspec_i(ins_ns),
    .ins_cls_i(ins_c), .ins_seq_i(ins_s),
    .rel_valid_i(rel_v), .rel_seq_i(rel_s),
    .sq_valid_i(sq_v), .sq_seq_i(sq_s),
    .iss_valid_o(iss_v), .iss_seq_o(iss_s), .iss_cls_o(iss_c),
    .free_cnt_o(free_cnt), .full_o(full)
  );

  typedef struct {
    logic [T-1:0]      vm;
    logic [T-1:0][7:0] sq;
    logic [T-1:0][2:0] cl;
    int                fr;
    logic              fl;
    int                rq;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  // reference model of the window
  bit         m_vld [N];
  bit         m_rdy [N];
  bit         m_hold[N];
  int         m_cls [N];
  logic [7:0] m_seq [N];
  bit         rel_pv;
  logic [7:0] rel_ps;

  // staged stimulus
  logic [L-1:0]      s_iv, s_ir, s_ins;
  logic [L-1:0][2:0] s_ic;
  logic [L-1:0][7:0] s_is;
  logic              s_rv, s_qv;
  logic [7:0]        s_rs, s_qs;

  function automatic bit older(logic [7:0] a, logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    return d[7];
  endfunction

  function automatic bit younger(logic [7:0] a, logic [7:0] ref_s);
    logic [7:0] d;
    d = a - ref_s;
    return (d != 8'd0) && !d[7];
  endfunction

  task automatic clr_stage();
    s_iv = '0; s_ir = '0; s_ins = '0; s_ic = '0; s_is = '0;
    s_rv = 1'b0; s_rs = '0; s_qv = 1'b0; s_qs = '0;
  endtask

  task automatic put(int k, int s, int c, bit r, bit ns);
    s_iv[k] = 1'b1; s_ir[k] = r; s_ins[k] = ns;
    s_ic[k] = 3'(c); s_is[k] = 8'(s);
  endtask

  task automatic cyc(int rq);
    exp_t e;
    bit kill[N];
    bit taken[N];
    bit was_free[N];
    int used[5];
    int caps[5];
    int fr;
    int best;
    int ncls;
    caps = '{2, 1, 1, 1, 1};
    @(posedge clk);
    #1;
    ins_v = s_iv; ins_r = s_ir; ins_ns = s_ins; ins_c = s_ic; ins_s = s_is;
    rel_v = s_rv; rel_s = s_rs; sq_v = s_qv; sq_s = s_qs;
    e.vm = '0; e.sq = '0; e.cl = '0; e.rq = rq;
    fr = 0;
    for (int i = 0; i < N; i++) begin
      kill[i] = s_qv && m_vld[i] && younger(m_seq[i], s_qs);
      taken[i] = 1'b0;
      was_free[i] = !m_vld[i];
      if (!m_vld[i]) fr++;
    end
    for (int c = 0; c < 5; c++) used[c] = 0;
    e.fr = fr;
    e.fl = (fr == 0);
    for (int r = 0; r < T; r++) begin
      best = -1;
      for (int i = 0; i < N; i++) begin
        if (m_vld[i] && m_rdy[i] && !m_hold[i] && !kill[i] && !taken[i] &&
            used[m_cls[i]] < caps[m_cls[i]] &&
            (best < 0 || older(m_seq[i], m_seq[best]))) best = i;
      end
      if (best >= 0) begin
        taken[best] = 1'b1;
        used[m_cls[best]]++;
        e.vm[r] = 1'b1;
        e.sq[r] = m_seq[best];
        e.cl[r] = 3'(m_cls[best]);
      end
    end
    q.push_back(e);
    for (int i = 0; i < N; i++) begin
      if (taken[i] || kill[i]) m_vld[i] = 1'b0;
      else if (rel_pv && m_vld[i] && m_seq[i] == rel_ps) m_hold[i] = 1'b0;
    end
    for (int k = 0; k < L; k++) begin
      if (s_iv[k] && fr > 0) begin
        for (int i = 0; i < N; i++) begin
          if (was_free[i]) begin
            was_free[i] = 1'b0;
            ncls = (int'(s_ic[k]) > 4) ? 4 : int'(s_ic[k]);
            m_vld[i] = 1'b1; m_rdy[i] = s_ir[k]; m_hold[i] = s_ins[k];
            m_cls[i] = ncls; m_seq[i] = s_is[k];
            break;
          end
        end
        fr--;
      end
    end
    rel_pv = s_rv;
    rel_ps = s_rs;
    clr_stage();
  endtask

  task automatic chk(bit ok, string what, int rq, logic [31:0] act, logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp_v);
    end
  endtask

  // monitor: compares mid-cycle, one expected item per driven cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(iss_v == e.vm, "issue valid", e.rq, 32'(iss_v), 32'(e.vm));
        chk(iss_s == e.sq, "issue seq", e.rq, 32'(iss_s), 32'(e.sq));
        chk(iss_c == e.cl, "issue class", e.rq, 32'(iss_c), 32'(e.cl));
        chk((int'(free_cnt) == e.fr) && (full == e.fl), "free/full", e.rq,
            {full, 26'd0, free_cnt}, {e.fl, 26'd0, 5'(e.fr)});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_rdy[i] = 0; m_hold[i] = 0; m_cls[i] = 0; m_seq[i] = '0;
    end
    rel_pv = 0; rel_ps = '0;
    clr_stage();
    ins_v = '0; ins_r = '0; ins_ns = '0; ins_c = '0; ins_s = '0;
    rel_v = 0; rel_s = '0; sq_v = 0; sq_s = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cyc(9); // R9 empty after reset

    put(0, 1, 0, 1, 0); cyc(5); // R5 grant next cycle, freed after
    cyc(5); cyc(5);

    for (int k = 0; k < 4; k++) put(k, 10 + k, 0, 1, 0); // R3 integer cap of 2
    cyc(3); cyc(3); cyc(3); cyc(3);

    for (int k = 0; k < 4; k++) put(k, 20 + k, 0, 1, 0); // R3 total cap of 4
    cyc(3);
    put(0, 24, 1, 1, 0); put(1, 25, 2, 1, 0); put(2, 26, 3, 1, 0); put(3, 27, 4, 1, 0);
    cyc(3); cyc(3); cyc(3); cyc(3);

    put(0, 43, 0, 1, 0); put(1, 40, 4, 1, 0); put(2, 42, 1, 1, 0); put(3, 41, 0, 1, 0);
    cyc(1); cyc(4); cyc(1); // R1 age order across lanes, R4 packing

    put(0, 254, 0, 1, 0); put(1, 255, 0, 1, 0); put(2, 0, 0, 1, 0); put(3, 1, 0, 1, 0);
    cyc(1); cyc(1); cyc(1); // R1 wrap at 255 -> 0

    put(0, 50, 6, 1, 0); put(1, 51, 4, 1, 0); // R2 code 6 folds onto misc
    cyc(2); cyc(2); cyc(2);

    put(0, 60, 0, 0, 0); cyc(5); cyc(5); cyc(5); // R5 not-ready never issues

    put(0, 70, 0, 1, 1); cyc(6); cyc(6); cyc(6); // R6 held
    s_rv = 1; s_rs = 70; cyc(6); cyc(6); cyc(6); cyc(6);

    for (int k = 0; k < 4; k++) put(k, 80 + k, 0, 1, 1); // R7 squash younger
    cyc(7);
    s_qv = 1; s_qs = 81; cyc(7); cyc(7);
    s_rv = 1; s_rs = 80; cyc(7);
    s_rv = 1; s_rs = 81; cyc(7);
    s_rv = 1; s_rs = 83; cyc(7);
    cyc(7); cyc(7); cyc(7);

    put(0, 90, 0, 1, 1); cyc(7); // R7 squash beats release
    s_rv = 1; s_rs = 90; cyc(7);
    s_qv = 1; s_qs = 89; cyc(7);
    cyc(7); cyc(7); cyc(7);

    put(0, 100, 0, 1, 0); put(1, 101, 0, 1, 0); cyc(7); // R7 no grant to squashed
    s_qv = 1; s_qs = 100; cyc(7); cyc(7);

    s_qv = 1; s_qs = 59; cyc(8); // R8 flush then fill
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 4; k++) put(k, 110 + 4 * b + k, 0, 1, 1);
      cyc(8);
    end
    for (int k = 0; k < 4; k++) put(k, 126 + k, 0, 1, 1);
    cyc(8); cyc(8);
    s_rv = 1; s_rs = 110; cyc(8);
    cyc(8);
    put(0, 130, 0, 1, 1); put(1, 131, 0, 1, 1); cyc(8);
    put(0, 132, 0, 1, 1); put(1, 133, 0, 1, 1); cyc(8);
    s_rv = 1; s_rs = 126; cyc(8); cyc(8); cyc(8);
    s_qv = 1; s_qs = 109; cyc(8);
    cyc(8); cyc(8);

    repeat (2) @(negedge clk);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule